// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is one 8-bit input channel with a strobe handshake and an interrupt request. A peripheral drives a byte onto the port pins and pulls an active-low strobe. The block captures the byte on the strobe's falling edge and raises a buffer-full flag. Once the peripheral releases the strobe, the block raises an interrupt request, provided its enable flip-flop is set and no host read is in progress. The host then reads the captured byte. The interrupt request drops as soon as the read pulse goes high. The buffer-full flag clears when the read pulse ends.

The enable flip-flop has no register field of its own. It is written by a port C bit-set/reset command aimed at one fixed port C bit number, which is 4 by default; a channel placed at the other handshake position uses 2. If a new strobe arrives before the host has read the previous byte, the old byte is overwritten and a sticky overrun flag is raised.

All inputs are sampled on the rising clock edge. Edges on the strobe and the read pulse are found by comparing each sample with the one taken a cycle earlier.

Top module: `strobed_in_port`

## Requirements
- R1: While reset (rstN low) is asserted, and after it is released, rdData is 0, ibf is 0, irq is 0 and overrun is 0, and the enable flip-flop is cleared.
- R2: Take the first clock edge at which stbN is sampled low after being sampled high on the previous edge. At that edge, rdData takes the value on portPins and ibf is set. Keeping stbN low for further cycles captures nothing more.
- R3: rdData changes only at a strobe falling edge. Pin changes at any other time leave it unchanged.
- R4: ibf clears at the clock edge where rdEn is sampled low after being sampled high on the previous edge (end of read). If a strobe falling edge happens at that same edge, ibf stays set.
- R5: irq is high exactly when stbN is high, ibf is set, the enable flip-flop is 1 and rdEn is low. irq therefore drops as soon as a read begins.
- R6: A clock edge with cmdWr high and cmdBit equal to ENABLE_BIT (default 4) loads cmdVal into the enable flip-flop. A command with any other bit number leaves the enable unchanged.
- R7: A strobe falling edge while ibf is already set overwrites rdData and sets overrun. overrun then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portPins | input | 8 | Byte driven by the peripheral |
| stbN | input | 1 | Active-low peripheral strobe |
| rdEn | input | 1 | Host read pulse, high for the duration of a read |
| cmdWr | input | 1 | Port C bit-set/reset command valid |
| cmdBit | input | 3 | Port C bit number targeted by the command |
| cmdVal | input | 1 | Value written by the command (1 set, 0 clear) |
| rdData | output | 8 | Captured byte |
| ibf | output | 1 | Input buffer full |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Sticky: a byte was overwritten before it was read |

## Verification
The embedded assertions check these on every cycle: buffer-full rises after a capture, buffer-full clears after a read ends with no strobe at the same edge, overrun is sticky, irq is low during a read and after the enable is cleared, and the latch loads the pins that were sampled at the capture edge. The following can only be shown by the bench's scenarios, where a cycle-accurate reference model is compared against the outputs on every clock: a long strobe captures only once, a read end and a strobe at the same edge leave buffer-full set, a command to the wrong port C bit has no effect, and irq waits until the strobe is released.

// File: rtl/sip_pkg.sv
package sip_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;   // strobe falling edge seen this cycle
    logic readDone;  // host read pulse ended this cycle
  } ctlStrobes_t;
endpackage

// File: rtl/sip_datapath.sv
module sip_datapath
  import sip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] portPins,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] dataLatch;

  always_ff @(posedge clk) begin
    if (!rstN)             dataLatch <= '0;
    else if (strb.capture) dataLatch <= portPins;
  end

  assign rdData = dataLatch;

  // R2
  capture_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (rdData == $past(portPins)));

  // R3
  hold_without_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && $past(rstN)) |=> $stable(rdData));
endmodule

// File: rtl/sip_ctrl.sv
module sip_ctrl
  import sip_pkg::*;
#(
  parameter int CMD_W      = 3,
  parameter int ENABLE_BIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stbN,
  input  logic             rdEn,
  input  logic             cmdWr,
  input  logic [CMD_W-1:0] cmdBit,
  input  logic             cmdVal,
  output ctlStrobes_t      strb,
  output logic             ibf,
  output logic             irq,
  output logic             overrun
);
  localparam logic [CMD_W-1:0] EnSel = CMD_W'(ENABLE_BIT);

  logic stbPrev, rdPrev, fullReg, ovrReg, inteReg;
  logic enCmd;

  assign strb.capture  = stbPrev & ~stbN;
  assign strb.readDone = rdPrev & ~rdEn;
  assign enCmd         = cmdWr && (cmdBit == EnSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbPrev <= 1'b1;
      rdPrev  <= 1'b0;
      fullReg <= 1'b0;
      ovrReg  <= 1'b0;
      inteReg <= 1'b0;
    end else begin
      stbPrev <= stbN;
      rdPrev  <= rdEn;
      if (strb.capture) begin
        fullReg <= 1'b1;
        if (fullReg) ovrReg <= 1'b1;
      end else if (strb.readDone) begin
        fullReg <= 1'b0;
      end
      if (enCmd) inteReg <= cmdVal;
    end
  end

  assign ibf     = fullReg;
  assign overrun = ovrReg;
  assign irq     = stbN & fullReg & inteReg & ~rdEn;

  // R2
  full_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> ibf);

  // R4
  full_clears_on_read_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readDone && !strb.capture) |=> !ibf);

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R7
  overrun_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && ibf) |=> overrun);

  // R5
  no_irq_in_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> !irq);

  // R6
  enable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enCmd && !cmdVal) |=> !irq);
endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port #(
  parameter int DATA_W     = 8,
  parameter int CMD_W      = 3,
  parameter int ENABLE_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] portPins,
  input  logic              stbN,
  input  logic              rdEn,
  input  logic              cmdWr,
  input  logic [CMD_W-1:0]  cmdBit,
  input  logic              cmdVal,
  output logic [DATA_W-1:0] rdData,
  output logic              ibf,
  output logic              irq,
  output logic              overrun
);
  sip_pkg::ctlStrobes_t strb;

  sip_ctrl #(.CMD_W(CMD_W), .ENABLE_BIT(ENABLE_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .stbN(stbN), .rdEn(rdEn),
    .cmdWr(cmdWr), .cmdBit(cmdBit), .cmdVal(cmdVal),
    .strb(strb), .ibf(ibf), .irq(irq), .overrun(overrun)
  );

  sip_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .portPins(portPins), .rdData(rdData)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (rdData == '0 && !ibf && !overrun && !irq));
endmodule

// File: tb/strobed_in_port_tb.sv
module strobed_in_port_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] portPins = 8'h00;
  logic       stbN = 1'b1;
  logic       rdEn = 1'b0;
  logic       cmdWr = 1'b0;
  logic [2:0] cmdBit = 3'd0;
  logic       cmdVal = 1'b0;
  logic [7:0] rdData;
  logic       ibf, irq, overrun;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string curReq = "R1";

  // reference model state
  int  mData = 0;
  bit  mIbf = 0, mOvr = 0, mInte = 0, mStbPrev = 1, mRdPrev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobed_in_port dut_i (
    .clk(clk), .rstN(rstN), .portPins(portPins), .stbN(stbN), .rdEn(rdEn),
    .cmdWr(cmdWr), .cmdBit(cmdBit), .cmdVal(cmdVal),
    .rdData(rdData), .ibf(ibf), .irq(irq), .overrun(overrun)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mData = 0; mIbf = 0; mOvr = 0; mInte = 0; mStbPrev = 1; mRdPrev = 0;
    end else begin
      if (mStbPrev && !stbN) begin
        if (mIbf) mOvr = 1;
        mIbf  = 1;
        mData = portPins;
      end else if (mRdPrev && !rdEn) begin
        mIbf = 0;
      end
      if (cmdWr && cmdBit == 3'd4) mInte = cmdVal;
      mStbPrev = stbN;
      mRdPrev  = rdEn;
    end
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("rdData", rdData, mData);
      chk("ibf", ibf, mIbf);
      chk("overrun", overrun, mOvr);
      chk("irq", irq, (stbN && mIbf && mInte && !rdEn) ? 1 : 0);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(logic [7:0] v, int lowCycles);
    portPins = v; stbN = 1'b0;
    step(lowCycles);
    portPins = ~v;
    step(1);
    stbN = 1'b1;
    step(2);
  endtask

  task automatic hostRead(int cycles);
    rdEn = 1'b1; step(cycles);
    rdEn = 1'b0; step(2);
  endtask

  task automatic bsr(logic [2:0] b, logic v);
    cmdWr = 1'b1; cmdBit = b; cmdVal = v; step(1);
    cmdWr = 1'b0; step(1);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    curReq = "R1";
    step(3);
    rstN = 1'b1;
    step(2);
    curReq = "R6"; bsr(3'd4, 1'b1);
    curReq = "R2"; strobe(8'hA5, 3);
    curReq = "R3"; portPins = 8'h3C; step(3);
    curReq = "R5"; hostRead(2);
    curReq = "R6"; bsr(3'd2, 1'b0);
    curReq = "R5"; strobe(8'h5A, 1);
    curReq = "R7"; strobe(8'hC3, 2);
    curReq = "R4"; hostRead(1);
    // read end coinciding with a strobe fall
    curReq = "R4";
    strobe(8'h11, 1);
    rdEn = 1'b1; step(1);
    rdEn = 1'b0; portPins = 8'h77; stbN = 1'b0; step(1);
    stbN = 1'b1; step(2);
    curReq = "R6"; bsr(3'd4, 1'b0); step(2);
    curReq = "R4"; hostRead(1);
    curReq = "R1"; rstN = 1'b0; step(2); rstN = 1'b1; step(2);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
    end
  end
endmodule